// File: doc/BRIEF.md
# Video Frame Dimension Checker

This block watches a pixel stream in which each beat may carry a start-of-frame marker and an end-of-line marker. Alongside the pixels, an image information record announces the width and height the next frame should have, plus a flag saying the sender already considers that frame broken. The block counts pixels in every line and lines in every frame. It compares the counts against the announced values and issues exactly one verdict per frame: broken or good, with the measured width and height.

Both the announced and the measured dimensions are clipped to configured maxima before the comparison. A frame completes when its line count reaches the announced height. A start-of-frame that arrives while a frame is still open closes that frame early as a short frame. Each verdict also says what a downstream writer should do with the frame, based on a drop-enable input. A broken frame is either marked for discard, or passed on with its broken flag forced high. A saturating counter tracks how many broken frames have been seen.

Top module: `frame_dim_checker`

## Requirements
- R1: While reset is asserted, and after it is released until the first frame closes, `vrd_valid` is 0 and `invalid_count` is 0.
- R2: The announced width and height are clipped to MAX_W and MAX_H. The pixel count of a line saturates at MAX_W. `vrd_width` never exceeds MAX_W and `vrd_height` never exceeds MAX_H.
- R3: A frame completes on the end-of-line beat that brings its line count up to the clipped announced height, when that height is nonzero. Its verdict appears on the clock edge that samples that beat, with `vrd_height` equal to the clipped height and `vrd_width` equal to the clipped width of that last line.
- R4: `vrd_broken` is 1 exactly when the record's broken flag was set, or any completed line's clipped width differs from the clipped announced width, or the completed line count differs from the clipped announced height.
- R5: A start-of-frame beat while a frame is open closes that frame as short. The short frame's verdict is broken, with `vrd_height` equal to its completed lines and `vrd_width` equal to its last completed line's width, or 0 if it has none.
- R6: Every closed frame yields exactly one single-cycle `vrd_valid` pulse. Verdicts come out in the order the frames closed.
- R7: On a verdict, `vrd_drop` = broken AND `drop_broken_en`, and `vrd_flag` = broken AND NOT `drop_broken_en`. Both are 0 for a good frame.
- R8: `invalid_count` rises by exactly 1 on each broken verdict, in the cycle `vrd_valid` is high, and holds at 2^CNT_W-1 once it gets there.
- R9: Beats that arrive after a frame has completed and before the next start-of-frame produce no verdict and leave `invalid_count` unchanged.
- R10: A record written with `info_valid` applies to the next start-of-frame. A record on the start-of-frame beat itself applies to that frame. A record written mid-frame does not change the frame in progress.
- R11: When a start-of-frame beat both closes the open frame and completes a one-line new frame, the short frame's verdict comes out first. The new frame's verdict follows on the next cycle.
- R12: `drop_broken_en` has no effect on `vrd_broken`, `vrd_width`, `vrd_height` or `invalid_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drop_broken_en | input | 1 | 1: broken frames are marked for discard; 0: they pass with the flag forced |
| info_valid | input | 1 | Image information record strobe |
| info_width | input | DIM_W | Announced pixels per line |
| info_height | input | DIM_W | Announced lines per frame |
| info_broken | input | 1 | Broken flag carried by the record |
| pix_valid | input | 1 | Pixel beat present |
| pix_sof | input | 1 | Beat is the first pixel of a frame |
| pix_eol | input | 1 | Beat is the last pixel of a line |
| vrd_valid | output | 1 | One-cycle verdict strobe |
| vrd_broken | output | 1 | Frame judged broken |
| vrd_drop | output | 1 | Discard request for this frame |
| vrd_flag | output | 1 | Broken flag value to emit with this frame |
| vrd_width | output | DIM_W | Clipped width of the last completed line |
| vrd_height | output | DIM_W | Completed line count |
| invalid_count | output | CNT_W | Saturating count of broken frames |

## Verification
The bench builds the block with DIM_W=3, MAX_W=3, MAX_H=3 and CNT_W=8. With those values, the bench can sweep every announced width from 0 to 4 and every height from 1 to 4, which includes values above both maxima. Lines can be one pixel too wide, so they run past the width limit. Each frame is sent full or short, with and without the flag and with the record early or on the start beat, under both drop settings. About three hundred frames drive the counter into saturation. Directed runs cover stray beats after a completed frame, a record arriving mid-frame, and a one-line frame whose start beat closes a short one.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
  // Which candidate the verdict stage emits in a given cycle.
  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_HELD,
    SRC_SHORT,
    SRC_FULL
  } vsrc_e;
endpackage

// File: rtl/fdc_line_meter.sv
module fdc_line_meter #(
  parameter int DW    = 12,
  parameter int MAX_W = 1920
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  input  logic          eol,
  output logic          line_end,
  output logic [DW-1:0] line_w
);
  localparam logic [DW-1:0] CAPW = DW'(MAX_W);

  logic [DW-1:0] cnt_q, cnt_d, base_c, cur_c;

  always_comb begin
    base_c = sof ? '0 : cnt_q;
    cur_c  = (base_c >= CAPW) ? CAPW : base_c + 1'b1;
    cnt_d  = eol ? '0 : cur_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (beat) cnt_q <= cnt_d;
  end

  assign line_end = beat & eol;
  assign line_w   = cur_c;

  // R2: the running pixel count never passes the width limit
  p_pix_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAPW);
endmodule

// File: rtl/fdc_frame_meter.sv
module fdc_frame_meter #(
  parameter int DW    = 12,
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  input  logic          line_end,
  input  logic [DW-1:0] line_w,
  input  logic          info_valid,
  input  logic [DW-1:0] info_w,
  input  logic [DW-1:0] info_h,
  input  logic          info_flag,
  output logic          short_v,
  output logic          short_brk,
  output logic [DW-1:0] short_w,
  output logic [DW-1:0] short_h,
  output logic          full_v,
  output logic          full_brk,
  output logic [DW-1:0] full_w,
  output logic [DW-1:0] full_h
);
  localparam logic [DW-1:0] CAPW = DW'(MAX_W);
  localparam logic [DW-1:0] CAPH = DW'(MAX_H);

  // pending record
  logic [DW-1:0] pw_q, ph_q;
  logic          pf_q;
  logic [DW-1:0] in_w_c, in_h_c, nw_c, nh_c;
  logic          nf_c;

  // frame in progress
  logic          open_q, open_d;
  logic [DW-1:0] lines_q, lines_d, ew_q, ew_d, eh_q, eh_d, lw_q, lw_d;
  logic          fl_q, fl_d, bad_q, bad_d;

  logic          start_c, lend_c, hit_c, bad_inc_c;
  logic [DW-1:0] lines_inc_c;

  always_comb begin
    in_w_c = (info_w > CAPW) ? CAPW : info_w;
    in_h_c = (info_h > CAPH) ? CAPH : info_h;
    nw_c   = info_valid ? in_w_c    : pw_q;
    nh_c   = info_valid ? in_h_c    : ph_q;
    nf_c   = info_valid ? info_flag : pf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pw_q <= '0;
      ph_q <= '0;
      pf_q <= 1'b0;
    end else if (info_valid) begin
      pw_q <= in_w_c;
      ph_q <= in_h_c;
      pf_q <= info_flag;
    end
  end

  always_comb begin
    start_c = beat & sof;
    // context the current beat belongs to
    open_d  = start_c | open_q;
    lines_d = start_c ? '0   : lines_q;
    ew_d    = start_c ? nw_c : ew_q;
    eh_d    = start_c ? nh_c : eh_q;
    fl_d    = start_c ? nf_c : fl_q;
    bad_d   = start_c ? 1'b0 : bad_q;
    lw_d    = start_c ? '0   : lw_q;

    lend_c      = line_end & open_d;
    lines_inc_c = (lines_d >= CAPH) ? CAPH : lines_d + 1'b1;
    bad_inc_c   = bad_d | (line_w != ew_d);
    hit_c       = lend_c & (lines_inc_c == eh_d);

    if (lend_c) begin
      lines_d = lines_inc_c;
      bad_d   = bad_inc_c;
      lw_d    = line_w;
    end
    if (hit_c) open_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      lines_q <= '0;
      ew_q    <= '0;
      eh_q    <= '0;
      fl_q    <= 1'b0;
      bad_q   <= 1'b0;
      lw_q    <= '0;
    end else if (beat) begin
      open_q  <= open_d;
      lines_q <= lines_d;
      ew_q    <= ew_d;
      eh_q    <= eh_d;
      fl_q    <= fl_d;
      bad_q   <= bad_d;
      lw_q    <= lw_d;
    end
  end

  assign short_v   = start_c & open_q;
  assign short_brk = fl_q | bad_q | (lines_q != eh_q);
  assign short_w   = lw_q;
  assign short_h   = lines_q;
  assign full_v    = hit_c;
  assign full_brk  = fl_d | bad_inc_c;
  assign full_w    = line_w;
  assign full_h    = lines_inc_c;

  // R3: an open frame has not yet reached its announced height
  p_open_below_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && eh_q != '0) |-> (lines_q < eh_q));
  // R5: a frame cut short by a new start is always broken
  p_short_broken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (short_v && eh_q != '0) |-> short_brk);
endmodule

// File: rtl/fdc_verdict.sv
module fdc_verdict
  import fdc_pkg::*;
#(
  parameter int DW    = 12,
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_en,
  input  logic             short_v,
  input  logic             short_brk,
  input  logic [DW-1:0]    short_w,
  input  logic [DW-1:0]    short_h,
  input  logic             full_v,
  input  logic             full_brk,
  input  logic [DW-1:0]    full_w,
  input  logic [DW-1:0]    full_h,
  output logic             vld,
  output logic             brk,
  output logic             drp,
  output logic             flg,
  output logic [DW-1:0]    wid,
  output logic [DW-1:0]    hgt,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [DW-1:0]    CAPW = DW'(MAX_W);
  localparam logic [DW-1:0]    CAPH = DW'(MAX_H);
  localparam logic [CNT_W-1:0] TOP  = '1;

  logic          held_q, held_d, hbrk_q;
  logic [DW-1:0] hw_q, hh_q;
  vsrc_e         src_c;
  logic          ebrk_c;
  logic [DW-1:0] ew_c, eh_c;

  logic             vld_q, brk_q, drp_q, flg_q;
  logic [DW-1:0]    w_q, h_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    if (held_q)       src_c = SRC_HELD;
    else if (short_v) src_c = SRC_SHORT;
    else if (full_v)  src_c = SRC_FULL;
    else              src_c = SRC_NONE;
    held_d = (held_q | short_v) & full_v;
    case (src_c)
      SRC_HELD:  begin ebrk_c = hbrk_q;    ew_c = hw_q;    eh_c = hh_q;    end
      SRC_SHORT: begin ebrk_c = short_brk; ew_c = short_w; eh_c = short_h; end
      SRC_FULL:  begin ebrk_c = full_brk;  ew_c = full_w;  eh_c = full_h;  end
      default:   begin ebrk_c = 1'b0;      ew_c = '0;      eh_c = '0;      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      hbrk_q <= 1'b0;
      hw_q   <= '0;
      hh_q   <= '0;
    end else begin
      held_q <= held_d;
      if (full_v) begin
        hbrk_q <= full_brk;
        hw_q   <= full_w;
        hh_q   <= full_h;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      brk_q <= 1'b0;
      drp_q <= 1'b0;
      flg_q <= 1'b0;
      w_q   <= '0;
      h_q   <= '0;
      cnt_q <= '0;
    end else begin
      vld_q <= (src_c != SRC_NONE);
      if (src_c != SRC_NONE) begin
        brk_q <= ebrk_c;
        drp_q <= ebrk_c & drop_en;
        flg_q <= ebrk_c & ~drop_en;
        w_q   <= ew_c;
        h_q   <= eh_c;
        if (ebrk_c && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vld = vld_q;
  assign brk = brk_q;
  assign drp = drp_q;
  assign flg = flg_q;
  assign wid = w_q;
  assign hgt = h_q;
  assign cnt = cnt_q;

  // R11: the single hold slot is never asked to hold two frames
  p_one_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(held_q && short_v));
  // R2: reported dimensions stay within the limits
  p_dims_clipped_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (w_q <= CAPW && h_q <= CAPH));
  // R7: discard and flag requests are exclusive and only for broken frames
  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (!(drp_q && flg_q) && ((drp_q | flg_q) == brk_q)));
  // R8: the counter only steps by one, on a broken verdict
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1 && vld_q && brk_q));
endmodule

// File: rtl/frame_dim_checker.sv
module frame_dim_checker #(
  parameter int DIM_W = 12,
  parameter int MAX_W = 1920,
  parameter int MAX_H = 1080,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop_broken_en,
  input  logic             info_valid,
  input  logic [DIM_W-1:0] info_width,
  input  logic [DIM_W-1:0] info_height,
  input  logic             info_broken,
  input  logic             pix_valid,
  input  logic             pix_sof,
  input  logic             pix_eol,
  output logic             vrd_valid,
  output logic             vrd_broken,
  output logic             vrd_drop,
  output logic             vrd_flag,
  output logic [DIM_W-1:0] vrd_width,
  output logic [DIM_W-1:0] vrd_height,
  output logic [CNT_W-1:0] invalid_count
);
  logic rs0_q, rs1_q, rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign rst_int_n = rs1_q;

  logic             line_end;
  logic [DIM_W-1:0] line_w;
  logic             short_v, short_brk, full_v, full_brk;
  logic [DIM_W-1:0] short_w, short_h, full_w, full_h;

  fdc_line_meter #(.DW(DIM_W), .MAX_W(MAX_W)) u_line (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .beat     (pix_valid),
    .sof      (pix_sof),
    .eol      (pix_eol),
    .line_end (line_end),
    .line_w   (line_w)
  );

  fdc_frame_meter #(.DW(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H)) u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .beat       (pix_valid),
    .sof        (pix_sof),
    .line_end   (line_end),
    .line_w     (line_w),
    .info_valid (info_valid),
    .info_w     (info_width),
    .info_h     (info_height),
    .info_flag  (info_broken),
    .short_v    (short_v),
    .short_brk  (short_brk),
    .short_w    (short_w),
    .short_h    (short_h),
    .full_v     (full_v),
    .full_brk   (full_brk),
    .full_w     (full_w),
    .full_h     (full_h)
  );

  fdc_verdict #(.DW(DIM_W), .MAX_W(MAX_W), .MAX_H(MAX_H), .CNT_W(CNT_W)) u_verdict (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .drop_en   (drop_broken_en),
    .short_v   (short_v),
    .short_brk (short_brk),
    .short_w   (short_w),
    .short_h   (short_h),
    .full_v    (full_v),
    .full_brk  (full_brk),
    .full_w    (full_w),
    .full_h    (full_h),
    .vld       (vrd_valid),
    .brk       (vrd_broken),
    .drp       (vrd_drop),
    .flg       (vrd_flag),
    .wid       (vrd_width),
    .hgt       (vrd_height),
    .cnt       (invalid_count)
  );
endmodule

// File: tb/sim_frame_dim_checker.sv
module sim_frame_dim_checker;
  localparam int DW = 3;
  localparam int MW = 3;
  localparam int MH = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drop_en = 1'b0;
  logic iv = 1'b0, ib = 1'b0, pv = 1'b0, ps = 1'b0, pe = 1'b0;
  logic [DW-1:0] iw = '0, ih = '0;
  logic vv, vb, vd, vf;
  logic [DW-1:0] vw, vh;
  logic [CW-1:0] cnt;

  always #10 clk = ~clk;

  frame_dim_checker #(.DIM_W(DW), .MAX_W(MW), .MAX_H(MH), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .drop_broken_en(drop_en),
    .info_valid(iv), .info_width(iw), .info_height(ih), .info_broken(ib),
    .pix_valid(pv), .pix_sof(ps), .pix_eol(pe),
    .vrd_valid(vv), .vrd_broken(vb), .vrd_drop(vd), .vrd_flag(vf),
    .vrd_width(vw), .vrd_height(vh), .invalid_count(cnt));

  typedef struct packed {
    logic       brk;
    logic       shrt;
    logic [7:0] w;
    logic [7:0] h;
  } exp_t;

  exp_t q[$];
  exp_t pend_e;
  exp_t mon_e;
  logic pend_short = 1'b0;
  logic armed = 1'b0;
  logic ended = 1'b0;
  int   n_vec = 0;
  int   n_bad = 0;
  int   exp_cnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Verdict monitor, sampled 1 ns after the rising edge.
  always @(posedge clk) begin
    #1;
    if (armed && vv) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6/R9 unexpected verdict", 1, 0);
      end else begin
        mon_e = q.pop_front();
        if (mon_e.brk && exp_cnt < 255) exp_cnt++;
        chk(vb == mon_e.brk, drop_en ? "R12 broken" : "R4 broken", int'(vb), int'(mon_e.brk));
        chk(vw == mon_e.w[DW-1:0], "R2 width", int'(vw), int'(mon_e.w));
        chk(vh == mon_e.h[DW-1:0], mon_e.shrt ? "R5 height" : "R3 height", int'(vh), int'(mon_e.h));
        chk(vd == (mon_e.brk & drop_en), "R7 drop", int'(vd), int'(mon_e.brk & drop_en));
        chk(vf == (mon_e.brk & ~drop_en), "R7 flag", int'(vf), int'(mon_e.brk & ~drop_en));
        chk(int'(cnt) == exp_cnt, drop_en ? "R12 count" : "R8 count", int'(cnt), exp_cnt);
      end
    end
  end

  task automatic drive(input bit v, input bit s, input bit e,
                       input bit i, input int w, input int h, input bit f);
    @(negedge clk);
    pv = v; ps = s; pe = e;
    iv = i; iw = DW'(w); ih = DW'(h); ib = f;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 0, 0, 0);
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // Sends one frame of n lines; expectation computed before any beat.
  task automatic send_frame(input int ew, input int eh, input bit fl,
                            input bit wv, input int n, input bit early);
    int   cw, ch, bw, len, mw, lastw;
    bit   bad, first;
    exp_t e;
    cw = mn(ew, MW);
    ch = mn(eh, MH);
    bw = (cw == 0) ? 1 : cw;
    bad = 1'b0;
    lastw = 0;
    for (int l = 0; l < n; l++) begin
      len = (wv && l == 0) ? bw + 1 : bw;
      mw = mn(len, MW);
      if (mw != cw) bad = 1'b1;
      lastw = mw;
    end
    e.brk  = fl | bad | (n != ch);
    e.shrt = (n != ch);
    e.w    = 8'(lastw);
    e.h    = 8'(n);
    if (pend_short) begin
      q.push_back(pend_e);
      pend_short = 1'b0;
    end
    if (n == ch) q.push_back(e);
    else begin
      pend_short = 1'b1;
      pend_e = e;
    end
    if (early) drive(0, 0, 0, 1, ew, eh, fl);
    first = 1'b1;
    if (n == 0) drive(1, 1, 0, !early, ew, eh, fl);
    for (int l = 0; l < n; l++) begin
      len = (wv && l == 0) ? bw + 1 : bw;
      for (int p = 0; p < len; p++) begin
        drive(1, first, p == len - 1, first && !early, ew, eh, fl);
        first = 1'b0;
      end
    end
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    armed = 1'b1;
    chk(vv == 1'b0, "R1 valid after reset", int'(vv), 0);
    chk(cnt == '0, "R1 count after reset", int'(cnt), 0);

    // Sweep under both drop settings (R2, R3, R4, R5, R7, R8, R12).
    for (int d = 0; d < 2; d++) begin
      drop_en = d[0];
      idle(2);
      for (int ew = 0; ew <= 4; ew++)
        for (int eh = 1; eh <= 4; eh++)
          for (int fl = 0; fl < 2; fl++)
            for (int wv = 0; wv < 2; wv++)
              for (int sh = 0; sh < 2; sh++)
                send_frame(ew, eh, fl[0], wv[0],
                           sh ? mn(eh, MH) - 1 : mn(eh, MH), ((ew + eh) % 2) == 1);
      send_frame(2, 2, 0, 0, 2, 0);
      idle(4);
      chk(q.size() == 0, "R6 verdicts outstanding", q.size(), 0);
    end

    // R9: stray beats after a completed frame.
    drop_en = 1'b0;
    send_frame(2, 1, 0, 0, 1, 0);
    idle(3);
    for (int k = 0; k < 6; k++) drive(1, 0, k % 2 == 1, 0, 0, 0, 0);
    idle(3);
    chk(q.size() == 0, "R9 verdict pending", q.size(), 0);
    chk(int'(cnt) == exp_cnt, "R9 count unchanged", int'(cnt), exp_cnt);

    // R10: record mid-frame applies only to the next frame.
    q.push_back('{brk: 1'b0, shrt: 1'b0, w: 8'd2, h: 8'd2});
    q.push_back('{brk: 1'b1, shrt: 1'b0, w: 8'd3, h: 8'd1});
    drive(0, 0, 0, 1, 2, 2, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 1, 3, 1, 1);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0, 0, 0);
    idle(3);
    chk(q.size() == 0, "R10 verdicts outstanding", q.size(), 0);

    // R11: start beat closes a short frame and completes a one-line frame.
    send_frame(3, 3, 0, 0, 1, 0);
    send_frame(1, 1, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(vv == 1'b1 && vb == 1'b1, "R11 short verdict first", int'(vv), 1);
    drive(0, 0, 0, 0, 0, 0, 0);
    chk(vv == 1'b1 && vb == 1'b0, "R11 one-line verdict next", int'(vv), 1);
    idle(3);
    chk(q.size() == 0, "R11 verdicts outstanding", q.size(), 0);
    chk(exp_cnt == 255, "R8 saturation reached", exp_cnt, 255);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule